// File: doc/BRIEF.md
# Double-Rate to Single-Rate Byte-Lane Adapter

This block sits between a four-lane, double-data-rate 10 Gb media-independent transmit interface and a soft PCS that works on a single clock edge. Each lane delivers one byte and one control flag on the rising clock edge and another byte and flag on the falling edge. The clock is the same on both sides. The adapter samples both edges and joins each rising/falling pair into one two-byte word per lane. The matching control flags are joined into a two-bit field. One new word per lane is produced on every rising edge, at the unchanged clock rate.

The rising-edge byte always lands in the low half of the word. The falling-edge byte that follows it lands in the high half. Because of this, a stream of bytes B0, B1, B2, B3 comes out as {B1,B0} and then {B3,B2}.

A synchronous active-high reset forces every output byte to the idle character 0x07 with its control flag set, and holds the valid indication low. Valid rises once the first complete pair has been assembled after reset.

Top module: `xgmii_ddr_to_sdr`

## Requirements
- R1: Lane n of `sdr_data` occupies bits [16n+15:16n], and lane n of `sdr_ctrl` occupies bits [2n+1:2n]. Each lane output depends only on the input byte bits [8n+7:8n] and the control bit n of the same lane.
- R2: When `sdr_valid` is high, the low byte of each lane word equals the byte that lane carried at the rising edge of the previous cycle.
- R3: When `sdr_valid` is high, the high byte of each lane word equals the byte that lane carried at the falling edge that followed that rising edge.
- R4: The control flags are paired in the same way. Bit 2n holds the rising-edge flag of lane n, and bit 2n+1 holds the falling-edge flag.
- R5: A pair whose rising byte is sampled at rising edge k appears on the outputs just after rising edge k+1. Consecutive pairs appear in arrival order, with no gap and no repeat.
- R6: At every rising edge where `rst` is high, and at the first rising edge after `rst` falls, every output byte becomes 0x07, every control bit becomes 1, and `sdr_valid` becomes 0.
- R7: `sdr_valid` goes high at the second rising edge with `rst` low. It then stays high until reset is asserted again.
- R8: Asserting `rst` in the middle of a stream discards any half-built pair. The outputs return to the R6 idle state at that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; both edges carry data |
| rst | input | 1 | Synchronous active-high reset |
| ddr_data | input | 32 | One byte per lane per clock edge, lane n in bits [8n+7:8n] |
| ddr_ctrl | input | 4 | Control flag per lane per clock edge, lane n in bit n |
| sdr_data | output | 64 | Paired word per lane, rising byte low, falling byte high |
| sdr_ctrl | output | 8 | Paired control flags per lane, rising flag in the even bit |
| sdr_valid | output | 1 | High once paired words are being delivered |

## Verification
The bench drives random bytes and flags on both edges. Every lane word is compared against a queue of completed pairs on every clock. A swapped byte order would put the falling byte in the low half, and a design that registered the wrong edge would deliver bytes one half-cycle late. Both show up on the first random pair. A single-lane pattern with idle neighbours catches crossed lane slices. A reset raised mid-stream, and the first edges after release, catch a design that leaks a stale half-pair or asserts valid one cycle early.

// File: rtl/xgmii_sdr_pkg.sv
package xgmii_sdr_pkg;

  // Idle character presented on every byte while the adapter is not delivering data
  localparam logic [7:0] IDLE_CHAR = 8'h07;

  // Build a word made of 'n' idle characters
  function automatic logic [63:0] idle_fill(input int unsigned n_bytes);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(n_bytes)) v[i*8 +: 8] = IDLE_CHAR;
    end
    return v;
  endfunction

endpackage

// File: rtl/ddr_edge_capture.sv
// Behavioural double-edge sampler for one lane: one register bank per edge.
module ddr_edge_capture #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] lane_byte,
  input  logic              lane_flag,
  output logic [BYTE_W-1:0] rise_byte,
  output logic              rise_flag,
  output logic [BYTE_W-1:0] fall_byte,
  output logic              fall_flag
);

  // Rising-edge half: becomes the low byte of the next word
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_byte <= '0;
      rise_flag <= 1'b0;
    end else begin
      rise_byte <= lane_byte;
      rise_flag <= lane_flag;
    end
  end

  // Falling-edge half: becomes the high byte of the next word
  always_ff @(negedge clk) begin
    if (rst) begin
      fall_byte <= '0;
      fall_flag <= 1'b0;
    end else begin
      fall_byte <= lane_byte;
      fall_flag <= lane_flag;
    end
  end

endmodule

// File: rtl/sdr_word_packer.sv
// Output register for one lane: joins the captured pair or drives idle.
module sdr_word_packer #(
  parameter int unsigned BYTE_W    = 8,
  parameter logic [7:0]  IDLE_CODE = 8'h07
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [BYTE_W-1:0]   rise_byte,
  input  logic                rise_flag,
  input  logic [BYTE_W-1:0]   fall_byte,
  input  logic                fall_flag,
  output logic [2*BYTE_W-1:0] word_q,
  output logic [1:0]          flags_q
);

  localparam logic [BYTE_W-1:0]   IDLE_B    = BYTE_W'(IDLE_CODE);
  localparam logic [2*BYTE_W-1:0] IDLE_WORD = {IDLE_B, IDLE_B};

  always_ff @(posedge clk) begin
    if (rst || !load) begin
      word_q  <= IDLE_WORD;
      flags_q <= 2'b11;
    end else begin
      word_q  <= {fall_byte, rise_byte};
      flags_q <= {fall_flag, rise_flag};
    end
  end

endmodule

// File: rtl/valid_tracker.sv
// Tracks whether a full pair has been captured since reset was released.
module valid_tracker (
  input  logic clk,
  input  logic rst,
  output logic primed,
  output logic valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      primed  <= 1'b1;
      valid_q <= primed;
    end
  end

  // R7: once valid, it stays valid until reset
  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

endmodule

// File: rtl/xgmii_ddr_to_sdr.sv
module xgmii_ddr_to_sdr #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned BYTE_W    = 8,
  parameter logic [7:0]  IDLE_CODE = xgmii_sdr_pkg::IDLE_CHAR
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LANES*BYTE_W-1:0]   ddr_data,
  input  logic [NUM_LANES-1:0]          ddr_ctrl,
  output logic [NUM_LANES*2*BYTE_W-1:0] sdr_data,
  output logic [NUM_LANES*2-1:0]        sdr_ctrl,
  output logic                          sdr_valid
);

  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic primed;

  valid_tracker u_valid (
    .clk     (clk),
    .rst     (rst),
    .primed  (primed),
    .valid_q (sdr_valid)
  );

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    logic [BYTE_W-1:0] rise_b, fall_b;
    logic              rise_f, fall_f;

    ddr_edge_capture #(.BYTE_W(BYTE_W)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .lane_byte (ddr_data[n*BYTE_W +: BYTE_W]),
      .lane_flag (ddr_ctrl[n]),
      .rise_byte (rise_b),
      .rise_flag (rise_f),
      .fall_byte (fall_b),
      .fall_flag (fall_f)
    );

    sdr_word_packer #(.BYTE_W(BYTE_W), .IDLE_CODE(IDLE_CODE)) u_pack (
      .clk       (clk),
      .rst       (rst),
      .load      (primed),
      .rise_byte (rise_b),
      .rise_flag (rise_f),
      .fall_byte (fall_b),
      .fall_flag (fall_f),
      .word_q    (sdr_data[n*WORD_W +: WORD_W]),
      .flags_q   (sdr_ctrl[2*n +: 2])
    );

    // R2: the low byte is the lane byte seen at the rising edge two samples back
    a_r2_low_byte_rise: assert property (@(posedge clk) disable iff (rst)
      sdr_valid |-> sdr_data[n*WORD_W +: BYTE_W] == $past(ddr_data[n*BYTE_W +: BYTE_W], 2));

    // R4: the even control bit follows the rising-edge flag
    a_r4_ctrl_low_rise: assert property (@(posedge clk) disable iff (rst)
      sdr_valid |-> sdr_ctrl[2*n] == $past(ddr_ctrl[n], 2));

    // R6: no valid data means idle characters on both bytes
    a_r6_idle_bytes: assert property (@(posedge clk) disable iff (rst)
      !sdr_valid |-> sdr_data[n*WORD_W +: WORD_W] == {BYTE_W'(IDLE_CODE), BYTE_W'(IDLE_CODE)});

    // R6: no valid data means both control bits are set
    a_r6_idle_ctrl: assert property (@(posedge clk) disable iff (rst)
      !sdr_valid |-> sdr_ctrl[2*n +: 2] == 2'b11);
  end

endmodule

// File: tb/tb_xgmii_ddr_to_sdr.sv
module tb_xgmii_ddr_to_sdr;

  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ddr_data = '0;
  logic [3:0]  ddr_ctrl = '0;
  logic [63:0] sdr_data;
  logic [7:0]  sdr_ctrl;
  logic        sdr_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase_tag = "";

  // Completed pairs, packed as {fc, f, rc, r}
  logic [71:0] pairs[$];

  always #2 clk = ~clk;

  xgmii_ddr_to_sdr dut (
    .clk(clk), .rst(rst), .ddr_data(ddr_data), .ddr_ctrl(ddr_ctrl),
    .sdr_data(sdr_data), .sdr_ctrl(sdr_ctrl), .sdr_valid(sdr_valid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, phase_tag, act, exp);
    end
  endtask

  // One full clock: rising-edge half, then falling-edge half
  task automatic cycle(input bit rst_v, input logic [31:0] r, input logic [3:0] rc,
                       input logic [31:0] f, input logic [3:0] fc);
    logic [71:0] p;
    bit          have;
    rst = rst_v; ddr_data = r; ddr_ctrl = rc;
    @(posedge clk); #1;
    have = 0;
    if (rst_v) pairs.delete();
    else if (pairs.size() > 0) begin p = pairs.pop_front(); have = 1; end
    if (!have) begin
      check(rst_v ? "R8 reset" : "R6 idle", {63'd0, sdr_valid}, 64'd0);
      for (int n = 0; n < LANES; n++) begin
        check("R6 idle word", {48'd0, sdr_data[n*16 +: 16]}, 64'h0707);
        check("R6 idle ctrl", {62'd0, sdr_ctrl[2*n +: 2]}, 64'd3);
      end
    end else begin
      check("R7 valid", {63'd0, sdr_valid}, 64'd1);
      for (int n = 0; n < LANES; n++) begin
        check("R2 low byte R5", {56'd0, sdr_data[n*16 +: 8]}, {56'd0, p[n*8 +: 8]});
        check("R3 high byte R5", {56'd0, sdr_data[n*16+8 +: 8]}, {56'd0, p[36+n*8 +: 8]});
        check("R4 ctrl pair", {62'd0, sdr_ctrl[2*n +: 2]}, {62'd0, p[68+n], p[32+n]});
      end
    end
    ddr_data = f; ddr_ctrl = fc;
    @(negedge clk); #1;
    if (!rst_v) pairs.push_back({fc, f, rc, r});
  endtask

  task automatic rand_cycles(input int count);
    for (int i = 0; i < count; i++)
      cycle(0, $urandom, 4'($urandom), $urandom, 4'($urandom));
  endtask

  initial begin
    phase_tag = "reset";
    for (int i = 0; i < 3; i++) cycle(1, $urandom, 4'($urandom), $urandom, 4'($urandom));
    phase_tag = "startup R7";
    rand_cycles(40);
    // R1: only one lane carries non-zero data, the others stay zero
    for (int ln = 0; ln < LANES; ln++) begin
      phase_tag = $sformatf("R1 lane %0d alone", ln);
      for (int i = 0; i < 3; i++)
        cycle(0, 32'(8'($urandom) | 8'h01) << (8*ln), 4'(1 << ln),
                 32'(8'($urandom) | 8'h80) << (8*ln), 4'd0);
    end
    phase_tag = "alternating";
    for (int i = 0; i < 6; i++) cycle(0, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 4'h0);
    phase_tag = "R8 midstream reset";
    cycle(1, 32'h1234_5678, 4'h5, 32'h9ABC_DEF0, 4'hA);
    cycle(1, 32'h1111_1111, 4'h0, 32'h2222_2222, 4'hF);
    phase_tag = "restart";
    rand_cycles(30);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule